// File: doc/BRIEF.md
# Converter Serial Register Port with Ready Signalling

This block is the device-side serial port of a multichannel converter's digital core. It is a mode-3 SPI slave. The host opens every exchange by shifting in an 8-bit command byte. The command picks one register of a small map and says whether the following bits are read or written. Conversion results come in from the converter core on a one-cycle valid strobe, with a 24-bit word and a 2-bit channel number. The block keeps the latest result together with a "no new data" flag.

The serial output line has two jobs. Between transfers, while chip select is low, it shows the ready flag: it drives low when a fresh result is waiting and high otherwise. During a read it carries the register bits. While chip select is high the line is driven high. A continuous-read mode lets the host clock a result out with no command, and each result can be taken this way only once. An optional control bit adds a status byte after each data word, and that byte names the result's channel. In 3-wire use chip select stays low, so the ready indication is always visible.

The SPI pins are sampled by the system clock through synchronizers, so the SCLK half period must span several system clocks. The controller has four states:
- `ST_IDLE`: chip select is high. It leaves for `ST_CMD` when chip select falls.
- `ST_CMD`: the command byte is being collected. It leaves for `ST_RD` on a valid read command, or on a continuous-read start. It leaves for `ST_WR` on a valid write command.
- `ST_RD`: register bits are shifting out. It returns to `ST_CMD` after the last bit.
- `ST_WR`: register bits are shifting in. It returns to `ST_CMD` after the last bit.

Any state goes to `ST_IDLE` when chip select rises.

Top module: `sdadc_spi_port`

## Requirements
- R1: After reset, the mode output and the interface-control output are zero. The ready flag reads as "no new data". The output line is high while chip select is high. A status read returns 0x80.
- R2: SCLK idles high. DIN is sampled on rising edges and output bits change on falling edges, MSB first. The first 8 bits after chip select falls form the command byte. Bit 7 of the command is 0 for a valid command. Bit 6 set means read and clear means write. Bits 5:0 are the address: 0x00 status, 0x01 mode, 0x02 interface control, 0x04 result data.
- R3: A write to 0x01 or 0x02 takes 16 bits. The new value appears on the matching configuration output once the 16th bit is taken.
- R4: A read returns the register MSB first. Status is 8 bits, mode and interface control are 16 bits, and data is 24 bits. Any unmapped address reads as 8 zero bits.
- R5: A result strobe stores the word and channel and clears the ready flag, which is bit 7 of status (0 = new data). While chip select is low and no read is shifting, the output line shows that flag. The line is high whenever chip select is high.
- R6: A complete data read sets the flag again, so the line goes high and stays high until the next result. The data register can be read again after that and returns the same word.
- R7: With interface-control bit 6 set, every data read carries 8 extra bits after the word. These bits are the status byte: flag in bit 7, zeros in bits 6:2, channel in bits 1:0.
- R8: With interface-control bit 7 set, a falling SCLK edge at the start of a byte while the flag shows new data starts output of the data word (plus the status byte if R7 is enabled) with no command. When that output ends, the result is consumed and the line goes high.
- R9: Chip select rising mid-transfer abandons it. The next transfer starts with a command byte, and a partial write changes nothing. An abandoned continuous-read output leaves the result pending.
- R10: The following have no effect on any register: writes to status, data or unmapped addresses (8 bits, or 24 for data), and command bytes with bit 7 set. After a discarded command byte, the next byte is taken as a command.
- R11: A result that arrives during a data read keeps the flag showing new data after that read ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host, idles high |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso_rdy | output | 1 | Serial data out, doubling as the ready indication |
| res_valid | input | 1 | One-cycle strobe marking a new conversion result |
| res_data | input | 24 | Conversion result word |
| res_chan | input | 2 | Channel number of the result |
| cfg_mode | output | 16 | Converter mode register contents |
| cfg_iface | output | 16 | Interface-control register contents |

## Verification
Most wrong internal states show up on the output line within one SCLK half period. A lost or spurious ready flag shows as a wrong level on the line between transfers. A bit counter that is off by one shifts every later data bit and misplaces the channel bits of the appended status byte. A controller that does not return to waiting for a command after an abort turns the next command byte into data, so the following configuration readback or continuous-read word comes back garbled. A wrongly committed write appears on the configuration outputs at once.

// File: rtl/sdadc_spi_pkg.sv
package sdadc_spi_pkg;
    localparam int CMD_W     = 8;
    localparam int ADDR_W    = 6;
    localparam int STAT_W    = 8;
    localparam int IF_CONT_B = 7;
    localparam int IF_APP_B  = 6;

    localparam logic [ADDR_W-1:0] A_STATUS = 6'h00;
    localparam logic [ADDR_W-1:0] A_MODE   = 6'h01;
    localparam logic [ADDR_W-1:0] A_IFACE  = 6'h02;
    localparam logic [ADDR_W-1:0] A_DATA   = 6'h04;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } spi_state_e;
endpackage

// File: rtl/sdadc_spi_sync.sv
module sdadc_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_hi,
    output logic mosi_s
);
    logic [STAGES-1:0] sclk_p, cs_p, mosi_p;
    logic              sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= '1;
            cs_p   <= '1;
            mosi_p <= '0;
            sclk_d <= 1'b1;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk};
            cs_p   <= {cs_p[STAGES-2:0], cs_n};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
            sclk_d <= sclk_p[STAGES-1];
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
    assign cs_hi     = cs_p[STAGES-1];
    assign mosi_s    = mosi_p[STAGES-1];
endmodule

// File: rtl/sdadc_result_hold.sv
module sdadc_result_hold #(
    parameter int DATA_W = 24,
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic              load,
    input  logic              consume,
    output logic [DATA_W-1:0] data_q,
    output logic [CHAN_W-1:0] chan_q,
    output logic              rdy_n
);
    logic newer;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            chan_q <= '0;
            rdy_n  <= 1'b1;
            newer  <= 1'b0;
        end else begin
            if (res_valid) begin
                data_q <= res_data;
                chan_q <= res_chan;
            end
            if (load)
                newer <= res_valid;
            else if (res_valid)
                newer <= 1'b1;
            if (res_valid)
                rdy_n <= 1'b0;
            else if (consume && !newer)
                rdy_n <= 1'b1;
        end
    end

    assert_ready_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !rdy_n);
    assert_ready_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> $past(consume));
endmodule

// File: rtl/sdadc_spi_fsm.sv
module sdadc_spi_fsm
    import sdadc_spi_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CFG_W  = 16,
    parameter int CHAN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_hi,
    input  logic              cs_n_raw,
    input  logic              mosi_s,
    input  logic              rdy_n,
    input  logic [DATA_W-1:0] data_q,
    input  logic [CHAN_W-1:0] chan_q,
    output logic              miso,
    output logic [CFG_W-1:0]  cfg_mode,
    output logic [CFG_W-1:0]  cfg_iface,
    output logic              load,
    output logic              consume
);
    localparam int SH_W  = DATA_W + STAT_W;
    localparam int LEN_W = $clog2(SH_W + 1);

    spi_state_e        state, state_n;
    logic [LEN_W-1:0]  cnt, len;
    logic [CMD_W-2:0]  cmd_sh;
    logic [SH_W-1:0]   sh;
    logic [ADDR_W-1:0] addr_q;
    logic              data_rd, dout_q;

    logic [CMD_W-1:0]  cmd_byte;
    logic              cmd_done, cmd_ok, cont_start, rd_done, wr_done;
    logic              cont_en, app_en;
    logic [STAT_W-1:0] stat_byte;
    logic [SH_W-1:0]   data_word;
    logic [CFG_W-1:0]  wr_val;

    function automatic logic [LEN_W-1:0] len_of(input logic [ADDR_W-1:0] a,
                                                 input logic rd, input logic app);
        if (a == A_MODE || a == A_IFACE) return LEN_W'(CFG_W);
        if (a == A_DATA) return LEN_W'(DATA_W + ((rd && app) ? STAT_W : 0));
        return LEN_W'(STAT_W);
    endfunction

    assign cont_en    = cfg_iface[IF_CONT_B];
    assign app_en     = cfg_iface[IF_APP_B];
    assign stat_byte  = {rdy_n, {(STAT_W-1-CHAN_W){1'b0}}, chan_q};
    assign data_word  = {data_q, stat_byte};
    assign cmd_byte   = {cmd_sh, mosi_s};
    assign cmd_ok     = !cmd_byte[7];
    assign cmd_done   = (state == ST_CMD) && sclk_rise && (cnt == LEN_W'(CMD_W-1));
    assign cont_start = (state == ST_CMD) && sclk_fall && (cnt == '0) && cont_en && !rdy_n;
    assign rd_done    = (state == ST_RD) && sclk_rise && (cnt == len - 1'b1);
    assign wr_done    = (state == ST_WR) && sclk_rise && (cnt == len - 1'b1);
    assign wr_val     = {sh[CFG_W-2:0], mosi_s};

    function automatic logic [SH_W-1:0] load_of(input logic [ADDR_W-1:0] a);
        unique case (a)
            A_STATUS: return {stat_byte, {(SH_W-STAT_W){1'b0}}};
            A_MODE:   return {cfg_mode, {(SH_W-CFG_W){1'b0}}};
            A_IFACE:  return {cfg_iface, {(SH_W-CFG_W){1'b0}}};
            A_DATA:   return data_word;
            default:  return '0;
        endcase
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state decision
    always_comb begin
        state_n = state;
        if (cs_hi) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_n = ST_CMD;
                ST_CMD: begin
                    if (cont_start)              state_n = ST_RD;
                    else if (cmd_done && cmd_ok) state_n = cmd_byte[6] ? ST_RD : ST_WR;
                end
                ST_RD: if (rd_done) state_n = ST_CMD;
                ST_WR: if (wr_done) state_n = ST_CMD;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            len       <= '0;
            cmd_sh    <= '0;
            sh        <= '0;
            addr_q    <= '0;
            data_rd   <= 1'b0;
            dout_q    <= 1'b1;
            cfg_mode  <= '0;
            cfg_iface <= '0;
        end else if (cs_hi) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: cnt <= '0;
                ST_CMD: begin
                    if (cont_start) begin
                        cnt     <= '0;
                        len     <= len_of(A_DATA, 1'b1, app_en);
                        sh      <= data_word << 1;
                        dout_q  <= data_word[SH_W-1];
                        data_rd <= 1'b1;
                    end else if (sclk_rise) begin
                        cmd_sh <= cmd_byte[CMD_W-2:0];
                        if (cmd_done) begin
                            cnt     <= '0;
                            addr_q  <= cmd_byte[ADDR_W-1:0];
                            len     <= len_of(cmd_byte[ADDR_W-1:0], cmd_byte[6], app_en);
                            data_rd <= cmd_byte[6] && (cmd_byte[ADDR_W-1:0] == A_DATA);
                            if (cmd_byte[6]) sh <= load_of(cmd_byte[ADDR_W-1:0]);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RD: begin
                    if (sclk_fall) begin
                        dout_q <= sh[SH_W-1];
                        sh     <= sh << 1;
                    end
                    if (sclk_rise) cnt <= rd_done ? '0 : cnt + 1'b1;
                end
                ST_WR: begin
                    if (sclk_rise) begin
                        sh  <= {sh[SH_W-2:0], mosi_s};
                        cnt <= wr_done ? '0 : cnt + 1'b1;
                        if (wr_done && addr_q == A_MODE)  cfg_mode  <= wr_val;
                        if (wr_done && addr_q == A_IFACE) cfg_iface <= wr_val;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        load    = cont_start || (cmd_done && cmd_ok && cmd_byte[6]
                                 && cmd_byte[ADDR_W-1:0] == A_DATA);
        consume = rd_done && data_rd;
        if (cs_n_raw)            miso = 1'b1;
        else if (state == ST_RD) miso = dout_q;
        else                     miso = rdy_n;
    end

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> state == ST_IDLE);
    assert_cfg_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_mode) |-> $past(state) == ST_WR);
    assert_cont_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && sclk_fall && cnt == '0 && rdy_n && !sclk_rise) |=> state != ST_RD);
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD || state == ST_WR) |-> cnt < len);
endmodule

// File: rtl/sdadc_spi_port.sv
module sdadc_spi_port #(
    parameter int DATA_W      = 24,
    parameter int CFG_W       = 16,
    parameter int CHAN_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso_rdy,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CHAN_W-1:0] res_chan,
    output logic [CFG_W-1:0]  cfg_mode,
    output logic [CFG_W-1:0]  cfg_iface
);
    logic              sclk_rise, sclk_fall, cs_hi, mosi_s;
    logic              load, consume, rdy_n;
    logic [DATA_W-1:0] data_q;
    logic [CHAN_W-1:0] chan_q;

    sdadc_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_hi(cs_hi), .mosi_s(mosi_s)
    );

    sdadc_result_hold #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .load(load), .consume(consume),
        .data_q(data_q), .chan_q(chan_q), .rdy_n(rdy_n)
    );

    sdadc_spi_fsm #(.DATA_W(DATA_W), .CFG_W(CFG_W), .CHAN_W(CHAN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_hi(cs_hi), .cs_n_raw(cs_n), .mosi_s(mosi_s), .rdy_n(rdy_n),
        .data_q(data_q), .chan_q(chan_q), .miso(miso_rdy),
        .cfg_mode(cfg_mode), .cfg_iface(cfg_iface), .load(load), .consume(consume)
    );
endmodule

// File: tb/sdadc_spi_port_test.sv
module sdadc_spi_port_test;
    localparam int HALF = 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic        miso_rdy, res_valid = 1'b0;
    logic [23:0] res_data = '0;
    logic [1:0]  res_chan = '0;
    logic [15:0] cfg_mode, cfg_iface;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    logic [15:0] e_mode = 0, e_if = 0;
    logic [23:0] e_data = 0;
    logic [1:0]  e_chan = 0;
    logic        e_rdy = 1;

    always #2 clk = ~clk;

    sdadc_spi_port uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso_rdy(miso_rdy), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .cfg_mode(cfg_mode), .cfg_iface(cfg_iface)
    );

    function automatic logic [7:0] stat_of(input logic r, input logic [1:0] c);
        return {r, 5'b0, c};
    endfunction

    function automatic int width_of(input logic [5:0] a, input logic app);
        if (a == 6'h01 || a == 6'h02) return 16;
        if (a == 6'h04) return app ? 32 : 24;
        return 8;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift(input int n, input logic [31:0] tx, output logic [31:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            sclk = 1'b0;
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso_rdy;
            sclk = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic sel(input logic lvl);
        wait_clk(4);
        cs_n = lvl;
        wait_clk(10);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] v, input int n);
        logic [31:0] d;
        sel(1'b0);
        shift(8, {24'b0, 2'b00, a}, d);
        shift(n, {16'b0, v}, d);
        sel(1'b1);
    endtask

    task automatic rd(input logic [5:0] a, input int n, output logic [31:0] v);
        logic [31:0] d;
        sel(1'b0);
        shift(8, {24'b0, 2'b01, a}, d);
        shift(n, 32'b0, v);
        sel(1'b1);
    endtask

    task automatic push(input logic [23:0] d, input logic [1:0] c);
        @(negedge clk);
        res_valid = 1'b1; res_data = d; res_chan = c;
        @(negedge clk);
        res_valid = 1'b0;
        e_data = d; e_chan = c; e_rdy = 1'b0;
        wait_clk(2);
    endtask

    task automatic rd_data_check(input string req);
        logic [31:0] v;
        logic app;
        app = e_if[6];
        rd(6'h04, width_of(6'h04, app), v);
        if (app) check(req, v, {e_data, stat_of(e_rdy, e_chan)});
        else     check(req, v, {8'b0, e_data});
        e_rdy = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, d;
        logic [15:0] rv;
        void'($urandom(32'd20240611));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1 reset state
        check("R1 line idle", {31'b0, miso_rdy}, 32'd1);
        check("R1 cfg_mode", {16'b0, cfg_mode}, 32'd0);
        check("R1 cfg_iface", {16'b0, cfg_iface}, 32'd0);
        rd(6'h00, 8, v);
        check("R1 status", v, 32'h80);

        // R2 R3 R4 random register writes and readback
        for (int i = 0; i < 6; i++) begin
            logic [5:0] a;
            a = (i % 2 == 0) ? 6'h01 : 6'h02;
            rv = 16'($urandom());
            if (a == 6'h02) rv[7] = 1'b0;
            wr(a, rv, 16);
            if (a == 6'h01) e_mode = rv; else e_if = rv;
            check("R3 cfg_mode port", {16'b0, cfg_mode}, {16'b0, e_mode});
            check("R3 cfg_iface port", {16'b0, cfg_iface}, {16'b0, e_if});
            rd(a, 16, v);
            check("R4 R2 readback", v, {16'b0, rv});
        end
        e_if = 16'h0000;
        wr(6'h02, e_if, 16);

        // R4 unmapped reads
        rd(6'h03, 8, v);
        check("R4 unmapped 03", v, 32'd0);
        rd(6'h3F, 8, v);
        check("R4 unmapped 3F", v, 32'd0);

        // R5 ready indication
        sel(1'b0);
        push(24'hA5C3E1, 2'd2);
        wait_clk(4);
        check("R5 line low while selected", {31'b0, miso_rdy}, 32'd0);
        sel(1'b1);
        check("R5 line high deselected", {31'b0, miso_rdy}, 32'd1);
        rd(6'h00, 8, v);
        check("R5 status flag and chan", v, {24'b0, stat_of(1'b0, 2'd2)});

        // R10 ignored writes
        wr(6'h00, 16'h00FF, 8);
        wr(6'h04, 16'hFFFF, 24);
        wr(6'h05, 16'h00FF, 8);
        check("R10 mode unchanged", {16'b0, cfg_mode}, {16'b0, e_mode});
        check("R10 iface unchanged", {16'b0, cfg_iface}, {16'b0, e_if});
        rd(6'h00, 8, v);
        check("R10 status unchanged", v, {24'b0, stat_of(1'b0, 2'd2)});
        sel(1'b0);
        shift(8, {24'b0, 8'h81}, d);
        shift(8, {24'b0, 8'h41}, d);
        shift(16, 32'b0, v);
        sel(1'b1);
        check("R10 discarded cmd then read", v, {16'b0, e_mode});
        check("R10 discarded cmd no write", {16'b0, cfg_mode}, {16'b0, e_mode});

        // R6 data read clears ready, reread works
        rd_data_check("R6 data read");
        sel(1'b0);
        check("R6 line high after read", {31'b0, miso_rdy}, 32'd1);
        sel(1'b1);
        rd(6'h04, 24, v);
        check("R6 reread", v, {8'b0, e_data});
        rd(6'h00, 8, v);
        check("R6 status flag set", v, {24'b0, stat_of(1'b1, e_chan)});

        // R7 appended status
        e_if = 16'h0040;
        wr(6'h02, e_if, 16);
        for (int i = 0; i < 3; i++) begin
            push(24'($urandom()), 2'($urandom()));
            rd_data_check("R7 appended status");
        end

        // R8 continuous read, with and without append
        for (int i = 0; i < 4; i++) begin
            e_if = (i < 2) ? 16'h0080 : 16'h00C0;
            wr(6'h02, e_if, 16);
            push(24'($urandom()), 2'($urandom()));
            sel(1'b0);
            check("R8 ready low before cont", {31'b0, miso_rdy}, 32'd0);
            shift(width_of(6'h04, e_if[6]), 32'b0, v);
            wait_clk(4);
            check("R8 line high after cont", {31'b0, miso_rdy}, 32'd1);
            sel(1'b1);
            if (e_if[6]) check("R8 cont word", v, {e_data, stat_of(1'b0, e_chan)});
            else         check("R8 cont word", v, {8'b0, e_data});
            e_rdy = 1'b1;
            rd(6'h00, 8, v);
            check("R8 consumed once", v, {24'b0, stat_of(1'b1, e_chan)});
        end

        // R9 abort in continuous read leaves result pending
        e_if = 16'h0080;
        wr(6'h02, e_if, 16);
        push(24'h13579B, 2'd1);
        sel(1'b0);
        shift(10, 32'b0, v);
        sel(1'b1);
        sel(1'b0);
        check("R9 still pending after abort", {31'b0, miso_rdy}, 32'd0);
        shift(24, 32'b0, v);
        sel(1'b1);
        check("R9 full cont after abort", v, {8'b0, e_data});
        e_rdy = 1'b1;
        e_if = 16'h0000;
        wr(6'h02, e_if, 16);
        check("R9 cont exit", {16'b0, cfg_iface}, 32'd0);

        // R9 partial write aborted
        sel(1'b0);
        shift(8, {24'b0, 8'h01}, d);
        shift(8, 32'h000000FF, d);
        sel(1'b1);
        check("R9 partial write", {16'b0, cfg_mode}, {16'b0, e_mode});
        rd(6'h01, 16, v);
        check("R9 command after abort", v, {16'b0, e_mode});

        // R11 result during a data read
        push(24'h0F0F0F, 2'd3);
        sel(1'b0);
        shift(8, {24'b0, 8'h44}, d);
        shift(10, 32'b0, v);
        push(24'h777777, 2'd0);
        shift(14, 32'b0, d);
        v = (v << 14) | d;
        wait_clk(4);
        check("R11 line still low", {31'b0, miso_rdy}, 32'd0);
        sel(1'b1);
        check("R11 first word", v & 32'h00FFFFFF, 32'h000F0F0F);
        rd_data_check("R11 second word");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule